// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This block takes one IEEE-754 binary32 operand and rounds it to an integral value. The result is still a binary32 number. An 8-bit control byte sets the behaviour of each operation. Its low two bits give a per-operation rounding mode. Bit 2 hands the choice of mode to a global 2-bit rounding-control input instead. Bit 3 masks the inexact flag. A flush input makes denormal operands count as zero of the same sign before rounding. Signaling NaNs come out quieted and raise the invalid flag. Quiet NaNs, infinities, zeros and values that are already integral pass through unchanged.

The block sits in a 128-bit scalar datapath whose destination may be wider than 128 bits. The rounded value always goes into lane 0 (bits 31:0). The rest of the destination depends on the form of the operation:
- **Two-operand form:** every bit from 32 upward keeps the old destination value.
- **Three-operand form:** bits 127:32 are copied from the first source, and every bit above 127 is cleared.

When `OUT_REG` is 1, a single register stage holds the output, and a two-state slot machine controls it:
- `SLOT_EMPTY` moves to `SLOT_FULL` on `in_valid` and captures the operation.
- `SLOT_FULL` stays in `SLOT_FULL` on `in_valid` and replaces the held operation.
- `SLOT_FULL` moves to `SLOT_EMPTY` when `in_valid` is low. The data and flags stay held.
- `SLOT_EMPTY` stays in `SLOT_EMPTY` when `in_valid` is low.

`out_valid` is high exactly in `SLOT_FULL`. When `OUT_REG` is 0, the path is purely combinational and `out_valid` equals `in_valid`.

Top module: `fp32_rint_unit`

## Requirements
- R1: The effective mode is `imm[1:0]` when `imm[2]` is 0, and `glob_rc` when `imm[2]` is 1, in which case `imm[1:0]` is ignored. Both use the same encoding: 00 is round to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 rounds toward zero.
- R2: In nearest mode, a value exactly halfway between two integers rounds to the even one (2.5 gives 2.0, 3.5 gives 4.0).
- R3: A nonzero magnitude below 1.0 gives a zero or 1.0 that carries the input's sign. For example, -0.3 rounded upward gives -0.0 (0x80000000), and -0.7 rounded downward gives -1.0.
- R4: When the rounding increment overflows the significand, the exponent rises by one and the fraction is zero (255.9 rounded upward gives 256.0, 0x43800000).
- R5: These inputs come out bit-for-bit unchanged with no flags: a biased exponent field (bits 30:23) of 150 or more, an infinity, or a zero.
- R6: An exponent field of 255 with a nonzero fraction and fraction bit 22 clear is a signaling NaN. It comes out with bit 22 set and raises `flag_invalid`. A NaN with bit 22 set passes unchanged with no flags. No other input raises `flag_invalid`.
- R7: With `imm[3]` = 0, `flag_inexact` is 1 exactly when the rounded value differs from the input. With `imm[3]` = 1, it is never raised.
- R8: With `daz` = 1, a denormal (exponent field 0, nonzero fraction) gives a zero of its own sign and no inexact flag. With `daz` = 0, it is rounded as a tiny nonzero value, for example to 1.0 in upward mode.
- R9: With `three_op` = 0, `result[DST_W-1:32]` equals `dst_old[DST_W-1:32]`.
- R10: With `three_op` = 1, `result[127:32]` equals `src_a[127:32]` and every bit of `result` above 127 is zero.
- R11: With `OUT_REG` = 1, each output reflects the inputs sampled at the previous rising clock edge while `in_valid` was 1. `out_valid` is the registered `in_valid`. Result and flags hold while `in_valid` is 0. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| imm | input | 8 | Control byte: [1:0] mode, [2] take global mode, [3] mask inexact |
| glob_rc | input | 2 | Global rounding-control value |
| daz | input | 1 | Treat denormal operands as signed zero |
| three_op | input | 1 | 1 selects the three-operand lane merge |
| src_a | input | SRC_W | First source; lanes above lane 0 feed the three-operand form |
| src_b | input | 32 | Scalar binary32 operand to be rounded |
| dst_old | input | DST_W | Previous destination contents |
| out_valid | output | 1 | Result valid |
| result | output | DST_W | Merged destination value |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Precision flag |

## Verification
The bench covers each rounding mode with these operands:
- Halfway values separate ties-to-even from plain round-half-up.
- Values just below 1.0 in magnitude, of both signs, expose a lost sign on zero results and wrong direction choices.
- A value that carries into the next binade catches a missing exponent bump.
- Already-integral and very large operands, infinities, zeros and both NaN kinds show that passthrough raises no spurious flag.
- Denormals with and without flushing separate the two treatments.

The same operand is then run with distinct upper-lane patterns in both forms. It is also run through idle cycles where the inputs change, to show the held state. A random sweep over all bit patterns, modes and control bits follows. A behavioural model built on real-number floor and ceiling checks every cycle of it.

// File: rtl/rint_pkg.sv
package rint_pkg;

    localparam int LANE_W     = 32;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int MANT_W     = FRAC_W + 1;
    localparam int BIAS       = 127;
    localparam int INT_LIMIT  = BIAS + FRAC_W;   // biased exponent at which no fraction bits remain
    localparam int SHIFT_W    = 5;

    // Control byte field positions
    localparam int IMM_MODE_LO    = 0;
    localparam int IMM_USE_GLOBAL = 2;
    localparam int IMM_MASK_PREC  = 3;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_ZERO      = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fclass_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } f32_t;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_FULL
    } slot_e;

endpackage

// File: rtl/rint_classify.sv
module rint_classify
    import rint_pkg::*;
(
    input  f32_t    op,
    input  logic    daz,
    output fclass_e cls,
    output f32_t    eff
);

    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    assign exp_zero  = (op.exp == '0);
    assign exp_ones  = (op.exp == '1);
    assign frac_zero = (op.frac == '0);

    always_comb begin
        eff = op;
        cls = CLS_NORMAL;
        if (exp_ones) begin
            if (frac_zero)
                cls = CLS_INF;
            else if (op.frac[FRAC_W-1])
                cls = CLS_QNAN;
            else
                cls = CLS_SNAN;
        end else if (exp_zero) begin
            if (frac_zero) begin
                cls = CLS_ZERO;
            end else if (daz) begin
                cls       = CLS_ZERO;
                eff.frac  = '0;
            end else begin
                cls = CLS_DENORM;
            end
        end
    end

endmodule

// File: rtl/rint_round.sv
module rint_round
    import rint_pkg::*;
(
    input  f32_t    eff,
    input  fclass_e cls,
    input  rmode_e  mode,
    output f32_t    res,
    output logic    lost,
    output logic    snan
);

    // Mid-range path: 1.0 <= |x| < 2^23
    logic [SHIFT_W-1:0] frac_bits;
    logic [MANT_W-1:0]  mant;
    logic [MANT_W-1:0]  mask;
    logic [MANT_W-1:0]  tail;
    logic [MANT_W-1:0]  kept;
    logic [MANT_W-1:0]  half;
    logic [MANT_W:0]    bumped;
    logic [MANT_W:0]    chosen;
    logic               tail_nz;
    logic               kept_odd;
    logic               mid_up;
    logic               small_up;
    logic               below_one;
    logic               all_int;

    assign frac_bits = SHIFT_W'(INT_LIMIT - int'(eff.exp));
    assign mant      = {1'b1, eff.frac};
    assign mask      = (MANT_W'(1) << frac_bits) - MANT_W'(1);
    assign tail      = mant & mask;
    assign kept      = mant & ~mask;
    assign half      = MANT_W'(1) << (frac_bits - SHIFT_W'(1));
    assign tail_nz   = (tail != '0);
    assign kept_odd  = mant[frac_bits];
    assign bumped    = {1'b0, kept} + ((MANT_W+1)'(1) << frac_bits);
    assign below_one = (int'(eff.exp) < BIAS);
    assign all_int   = (int'(eff.exp) >= INT_LIMIT);

    always_comb begin
        unique case (mode)
            RM_NEAR_EVEN: mid_up = (tail > half) || ((tail == half) && kept_odd);
            RM_DOWN:      mid_up = eff.sign && tail_nz;
            RM_UP:        mid_up = !eff.sign && tail_nz;
            RM_ZERO:      mid_up = 1'b0;
            default:      mid_up = 1'b0;
        endcase
    end

    // Magnitude strictly between 0 and 1: result is signed 0 or signed 1
    always_comb begin
        unique case (mode)
            RM_NEAR_EVEN: small_up = (int'(eff.exp) == BIAS - 1) && (eff.frac != '0);
            RM_DOWN:      small_up = eff.sign;
            RM_UP:        small_up = !eff.sign;
            RM_ZERO:      small_up = 1'b0;
            default:      small_up = 1'b0;
        endcase
    end

    assign chosen = mid_up ? bumped : {1'b0, kept};

    always_comb begin
        res  = eff;
        lost = 1'b0;
        snan = 1'b0;
        unique case (cls)
            CLS_SNAN: begin
                res.frac[FRAC_W-1] = 1'b1;
                snan               = 1'b1;
            end
            CLS_QNAN, CLS_INF, CLS_ZERO: begin
                res = eff;
            end
            CLS_DENORM: begin
                lost     = 1'b1;
                res.exp  = small_up ? EXP_W'(BIAS) : '0;
                res.frac = '0;
            end
            CLS_NORMAL: begin
                if (all_int) begin
                    res = eff;
                end else if (below_one) begin
                    lost     = 1'b1;
                    res.exp  = small_up ? EXP_W'(BIAS) : '0;
                    res.frac = '0;
                end else begin
                    lost = tail_nz;
                    if (chosen[MANT_W]) begin
                        res.exp  = eff.exp + EXP_W'(1);
                        res.frac = '0;
                    end else begin
                        res.frac = chosen[FRAC_W-1:0];
                    end
                end
            end
            default: res = eff;
        endcase
    end

endmodule

// File: rtl/rint_merge.sv
module rint_merge
    import rint_pkg::*;
#(
    parameter int DST_W = 256,
    parameter int SRC_W = 128
) (
    input  logic [LANE_W-1:0] lane0,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [DST_W-1:0]  dst_old,
    input  logic              three_op,
    output logic [DST_W-1:0]  merged
);

    logic unused_low;
    assign unused_low = ^{src_a[LANE_W-1:0], dst_old[LANE_W-1:0]};

    assign merged[LANE_W-1:0] = lane0;

    assign merged[SRC_W-1:LANE_W] = three_op ? src_a[SRC_W-1:LANE_W]
                                             : dst_old[SRC_W-1:LANE_W];

    generate
        if (DST_W > SRC_W) begin : g_wide
            assign merged[DST_W-1:SRC_W] = three_op ? '0 : dst_old[DST_W-1:SRC_W];
        end
    endgenerate

endmodule

// File: rtl/fp32_rint_unit.sv
module fp32_rint_unit
    import rint_pkg::*;
#(
    parameter int DST_W   = 256,
    parameter int SRC_W   = 128,
    parameter int OUT_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       imm,
    input  logic [1:0]       glob_rc,
    input  logic             daz,
    input  logic             three_op,
    input  logic [SRC_W-1:0] src_a,
    input  logic [31:0]      src_b,
    input  logic [DST_W-1:0] dst_old,
    output logic             out_valid,
    output logic [DST_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);

    localparam int UPPER_W = DST_W - LANE_W;

    logic    unused_imm;
    rmode_e  mode_sel;
    fclass_e cls;
    f32_t    eff;
    f32_t    lane_res;
    logic    lost;
    logic    snan;
    logic    nxt_inexact;
    logic [DST_W-1:0] nxt_result;

    assign unused_imm = ^imm[7:4];

    assign mode_sel = rmode_e'(imm[IMM_USE_GLOBAL] ? glob_rc : imm[IMM_MODE_LO +: 2]);

    rint_classify u_classify (
        .op  (f32_t'(src_b)),
        .daz (daz),
        .cls (cls),
        .eff (eff)
    );

    rint_round u_round (
        .eff  (eff),
        .cls  (cls),
        .mode (mode_sel),
        .res  (lane_res),
        .lost (lost),
        .snan (snan)
    );

    assign nxt_inexact = lost && !imm[IMM_MASK_PREC];

    rint_merge #(
        .DST_W (DST_W),
        .SRC_W (SRC_W)
    ) u_merge (
        .lane0    (lane_res),
        .src_a    (src_a),
        .dst_old  (dst_old),
        .three_op (three_op),
        .merged   (nxt_result)
    );

    // The quieting path must always set the quiet bit when invalid is raised
    AST_SNAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && snan) |-> (lane_res.exp == '1 && lane_res.frac[FRAC_W-1])); // R6

    generate
        if (OUT_REG != 0) begin : g_reg
            slot_e state_q;
            slot_e state_d;
            logic [DST_W-1:0] res_q;
            logic             inv_q;
            logic             inx_q;

            // Next-state selection
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    SLOT_EMPTY: state_d = in_valid ? SLOT_FULL : SLOT_EMPTY;
                    SLOT_FULL:  state_d = in_valid ? SLOT_FULL : SLOT_EMPTY;
                    default:    state_d = SLOT_EMPTY;
                endcase
            end

            // State register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    state_q <= SLOT_EMPTY;
                else
                    state_q <= state_d;
            end

            // Output payload: captured on every entry into or stay in SLOT_FULL
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                    inv_q <= 1'b0;
                    inx_q <= 1'b0;
                end else if (state_d == SLOT_FULL) begin
                    res_q <= nxt_result;
                    inv_q <= snan;
                    inx_q <= nxt_inexact;
                end
            end

            assign out_valid    = (state_q == SLOT_FULL);
            assign result       = res_q;
            assign flag_invalid = inv_q;
            assign flag_inexact = inx_q;

            AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R11
            AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid); // R11
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(result) && $stable(flag_invalid) && $stable(flag_inexact))); // R11
            AST_PREC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && imm[IMM_MASK_PREC]) |=> !flag_inexact); // R7
            AST_INVALID_ONLY_NAN: assert property (@(posedge clk) disable iff (!rst_n)
                flag_invalid |-> (result[30:23] == 8'hFF && result[22])); // R6
            AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !three_op) |=> (result[DST_W-1:LANE_W] == $past(dst_old[DST_W-1:LANE_W]))); // R9
            AST_INT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && src_b[30:23] >= 8'(INT_LIMIT)) |=> !flag_inexact); // R5
            if (DST_W > SRC_W) begin : g_zero_chk
                AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                    (in_valid && three_op) |=> (result[DST_W-1:SRC_W] == '0)); // R10
            end
        end else begin : g_comb
            assign out_valid    = in_valid;
            assign result       = nxt_result;
            assign flag_invalid = snan;
            assign flag_inexact = nxt_inexact;
        end
    endgenerate

    logic unused_width;
    assign unused_width = (UPPER_W > 0);

endmodule

// File: tb/fp32_rint_unit_tb.sv
`timescale 1ns/1ps
module fp32_rint_unit_tb;

    localparam int DW = 256;
    localparam int SW = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [7:0]    imm;
    logic [1:0]    glob_rc;
    logic          daz;
    logic          three_op;
    logic [SW-1:0] src_a;
    logic [31:0]   src_b;
    logic [DW-1:0] dst_old;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          flag_invalid;
    logic          flag_inexact;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] exp_res = '0;
    logic          exp_inv = 1'b0;
    logic          exp_inx = 1'b0;
    logic          exp_val = 1'b0;

    always #2.5 clk = ~clk;

    fp32_rint_unit #(.DST_W(DW), .SRC_W(SW), .OUT_REG(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm(imm),
        .glob_rc(glob_rc), .daz(daz), .three_op(three_op), .src_a(src_a),
        .src_b(src_b), .dst_old(dst_old), .out_valid(out_valid),
        .result(result), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    // Behavioural model: returns {invalid, inexact, lane0}
    function automatic logic [33:0] model(input logic [31:0] x, input logic [7:0] im,
                                          input logic [1:0] g, input logic dz);
        logic        s;
        int          e, f, m, n, p;
        real         mag, r, o;
        logic [31:0] y;
        logic        inx;
        s = x[31];
        e = int'(x[30:23]);
        f = int'(x[22:0]);
        m = im[2] ? int'(g) : int'(im[1:0]);
        if (e == 255) begin
            if (f == 0 || x[22]) return {2'b00, x};
            return {2'b10, x | 32'h0040_0000};
        end
        if (e == 0 && f == 0) return {2'b00, x};
        if (e == 0 && dz)     return {2'b00, s, 31'h0};
        if (e >= 150)         return {2'b00, x};
        if (e == 0) mag = f * (2.0 ** (-149));
        else        mag = (f + 8388608.0) * (2.0 ** (e - 150));
        r = s ? -mag : mag;
        case (m)
            0: begin
                o = $floor(r);
                if (r - o > 0.5) o = o + 1.0;
                else if (r - o == 0.5 && ($rtoi(o) % 2) != 0) o = o + 1.0;
            end
            1: o = $floor(r);
            2: o = $ceil(r);
            default: o = (r >= 0.0) ? $floor(r) : $ceil(r);
        endcase
        n = $rtoi(o < 0.0 ? -o : o);
        if (n == 0) y = {s, 31'h0};
        else begin
            p = 0;
            for (int i = 0; i < 25; i++) if ((n >> i) != 0) p = i;
            y = {s, 8'(127 + p), 23'((n << (23 - p)) & 32'h007F_FFFF)};
        end
        inx = (o != r) && !im[3];
        return {1'b0, inx, y};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (out_valid !== exp_val || result !== exp_res ||
            flag_invalid !== exp_inv || flag_inexact !== exp_inx) begin
            fails++;
            $display("FAIL %s: actual v=%0b inv=%0b inx=%0b res=%h expected v=%0b inv=%0b inx=%0b res=%h",
                     tag, out_valid, flag_invalid, flag_inexact, result,
                     exp_val, exp_inv, exp_inx, exp_res);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] im, input logic [1:0] g,
                        input logic dz, input logic t3, input logic [127:0] a,
                        input logic [31:0] b, input logic [255:0] old, input string tag);
        logic [33:0] mr;
        in_valid = v; imm = im; glob_rc = g; daz = dz; three_op = t3;
        src_a = a; src_b = b; dst_old = old;
        exp_val = v;
        if (v) begin
            mr      = model(b, im, g, dz);
            exp_inv = mr[33];
            exp_inx = mr[32];
            exp_res = t3 ? {128'h0, a[127:32], mr[31:0]} : {old[255:32], mr[31:0]};
        end
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [127:0] PA = 128'hA5A5_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0;
    localparam logic [255:0] PO = 256'hDEAD_BEEF_CAFE_F00D_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_1111_2222_3333_4444;

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; imm = 0; glob_rc = 0; daz = 0; three_op = 0;
        src_a = '0; src_b = '0; dst_old = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R11 reset");

        // R2 ties to even, R4 carry
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h4020_0000, PO, "R2 2.5");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h4060_0000, PO, "R2 3.5");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h3FC0_0000, PO, "R4 1.5");
        step(1, 8'h02, 2'b00, 0, 0, PA, 32'h437F_E666, PO, "R4 255.9 up");
        // R1 immediate modes
        step(1, 8'h01, 2'b10, 0, 0, PA, 32'hC020_0000, PO, "R1 floor -2.5");
        step(1, 8'h02, 2'b01, 0, 0, PA, 32'hC020_0000, PO, "R1 ceil -2.5");
        step(1, 8'h03, 2'b00, 0, 0, PA, 32'hC020_0000, PO, "R1 trunc -2.5");
        // R1 global mode
        step(1, 8'h04, 2'b01, 0, 0, PA, 32'h402C_CCCD, PO, "R1 global floor");
        step(1, 8'h06, 2'b11, 0, 0, PA, 32'hC02C_CCCD, PO, "R1 global trunc");
        step(1, 8'h07, 2'b10, 0, 0, PA, 32'h402C_CCCD, PO, "R1 global ceil");
        // R3 small magnitudes
        step(1, 8'h02, 2'b00, 0, 0, PA, 32'h3E99_999A, PO, "R3 0.3 up");
        step(1, 8'h02, 2'b00, 0, 0, PA, 32'hBE99_999A, PO, "R3 -0.3 up");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h3F00_0000, PO, "R3 0.5 near");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h3F33_3333, PO, "R3 0.7 near");
        step(1, 8'h01, 2'b00, 0, 0, PA, 32'hBF33_3333, PO, "R3 -0.7 down");
        step(1, 8'h03, 2'b00, 0, 0, PA, 32'hBF33_3333, PO, "R3 -0.7 trunc");
        // R5 passthrough
        step(1, 8'h02, 2'b00, 0, 0, PA, 32'h5015_02F9, PO, "R5 large");
        step(1, 8'h01, 2'b00, 0, 0, PA, 32'h4B00_0001, PO, "R5 2^23+1");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h7F80_0000, PO, "R5 inf");
        step(1, 8'h02, 2'b00, 0, 0, PA, 32'h8000_0000, PO, "R5 -0");
        // R6 NaNs
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h7F80_0001, PO, "R6 snan");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'hFFC0_0005, PO, "R6 qnan");
        // R7 precision mask
        step(1, 8'h08, 2'b00, 0, 0, PA, 32'h4020_0000, PO, "R7 masked");
        step(1, 8'h00, 2'b00, 0, 0, PA, 32'h4040_0000, PO, "R7 exact");
        // R8 denormals
        step(1, 8'h02, 2'b00, 1, 0, PA, 32'h0000_0001, PO, "R8 daz on");
        step(1, 8'h02, 2'b00, 0, 0, PA, 32'h0000_0001, PO, "R8 daz off");
        step(1, 8'h01, 2'b00, 1, 0, PA, 32'h8040_0000, PO, "R8 neg daz");
        // R9 / R10 lane merge
        step(1, 8'h00, 2'b00, 0, 0, ~PA, 32'h4020_0000, ~PO, "R9 legacy");
        step(1, 8'h00, 2'b00, 0, 1, PA, 32'h4020_0000, PO, "R10 three op");
        step(1, 8'h00, 2'b00, 0, 1, ~PA, 32'hC060_0000, ~PO, "R10 three op b");
        // R11 hold while idle with changing inputs
        step(0, 8'h0F, 2'b11, 1, 0, ~PA, 32'h3F80_0000, ~PO, "R11 idle");
        step(0, 8'h00, 2'b00, 0, 1, PA, 32'h7F80_0001, PO, "R11 idle hold");
        step(1, 8'h01, 2'b00, 0, 0, PA, 32'h4020_0000, PO, "R11 resume");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] rb;
            rb = $urandom;
            if (k % 3 == 0) rb[30:23] = 8'(120 + ($urandom % 32));
            step(1'($urandom % 8 != 0), 8'($urandom), 2'($urandom), 1'($urandom),
                 1'($urandom), {$urandom, $urandom, $urandom, $urandom}, rb,
                 {8{$urandom}}, "R1 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule